// File: doc/BRIEF.md
# Vblank-Latched Sprite Surface Registers

This block holds the surface stride and surface start address for one sprite plane. Each value exists twice: a staged copy that software writes, and a live copy that feeds the display fetch logic. Writing the stride on its own changes nothing on the live side. A later write to the start address arms a commit. On the next vertical blanking pulse, both staged values move to the live copies in the same cycle.

Writes reach the block from two places. One is a memory-mapped register bus with a valid/ready handshake. The other is a command-stream write port with no back-pressure. Arbitration between them is fixed: the command port always wins. When `cmd_valid` is high, `rb_ready` is held low, so a register-bus write simply waits. A bus write completes on a rising edge where both `rb_valid` and `rb_ready` are high, and the bus master must hold its address and data until then. The command port is never stalled, and a command write takes effect on the edge where `cmd_valid` is high.

The block also watches the staged stride against the rules of the selected memory layout and raises a sticky error flag when a rule is broken. Software clears the flag by writing one to it.

Register selects are 2 bits wide:
- 0 is the stride.
- 1 is the start address.
- 2 is status, with bit 0 the sticky error flag (write one to clear) and bit 1 the commit-pending flag (read only).
- 3 reads as zero and ignores writes.

Top module: `sprite_surf_regs`

## Requirements
- R1: After reset, the staged stride, staged start, live stride and live start are all 0x00000000, both status bits (error and pending) are 0, and `rb_ready` is 1.
- R2: Stride bits 5:0 always read as zero, and writes to them are ignored; bits 31:6 store the written value.
- R3: A stride write with no later start write never reaches the live stride, however many vblank pulses occur, and it leaves the pending flag (status bit 1) at 0.
- R4: A start write sets status bit 1. The next cycle with `vblank` high copies both staged values into the live outputs at once and clears status bit 1.
- R5: A vblank pulse while status bit 1 is 0 leaves both live outputs unchanged.
- R6: A start write on the same cycle as a committing vblank behaves as follows: the commit uses the staged values from before that write, status bit 1 stays 1, and the following vblank commits the newly written start.
- R7: When `cmd_valid` is high, `rb_ready` is 0 and the command write is the one applied. A waiting register-bus write is applied on the first edge after `cmd_valid` falls.
- R8: In tiled mode (`tiled` = 1), a staged stride that is not a multiple of 256, or that is greater than 16384, sets status bit 0 one cycle later. A stride of exactly 16384 is legal. In linear mode, every stride is legal, because bits 5:0 are always zero and so the stride is always a multiple of 64.
- R9: Status bit 0 stays set until a status write with data bit 0 = 1. If the violation still holds on the cycle of that write, the bit stays set.
- R10: `rd_data` combinationally returns the register chosen by `rd_addr`, using the map given above. Select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tiled | input | 1 | Memory layout: 1 = tiled, 0 = linear |
| vblank | input | 1 | Vertical blanking event, one cycle wide |
| rb_valid | input | 1 | Register-bus write request |
| rb_ready | output | 1 | Register-bus write accepted when high with `rb_valid` |
| rb_addr | input | 2 | Register-bus write select |
| rb_wdata | input | 32 | Register-bus write data |
| cmd_valid | input | 1 | Command-stream write, always accepted |
| cmd_addr | input | 2 | Command-stream write select |
| cmd_data | input | 32 | Command-stream write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | 32 | Read data |
| live_stride | output | 32 | Live stride driving the fetch logic |
| live_start | output | 32 | Live start address driving the fetch logic |

## Verification
The assertions check the following on every cycle:
- The reserved stride bits stay zero.
- A committing vblank copies both staged values into the live outputs on the next edge.
- The live outputs hold still in every cycle without a commit.
- The pending flag clears, or re-arms, correctly around a commit.
- The bus is stalled whenever the command port writes.
- The error flag only drops through a clear write.

The bench scenarios cover what the assertions cannot:
- The error flag is swept over hundreds of stride values in both layouts, and each expected result is computed from the alignment and 16K rules.
- A stride written alone stays staged across many vblanks.
- Read-back shows that the stalled bus write lands after the command write.

// File: rtl/surf_pkg.sv
package surf_pkg;
  typedef enum logic [1:0] {
    SEL_STRIDE = 2'd0,
    SEL_START  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/surf_wr_arb.sv
module surf_wr_arb #(
  parameter int DW = 32
) (
  input  logic          rb_valid,
  input  logic [1:0]    rb_addr,
  input  logic [DW-1:0] rb_wdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          rb_ready,
  output logic          wr_en,
  output logic [1:0]    wr_addr,
  output logic [DW-1:0] wr_data
);
  // command stream has fixed priority; bus waits while it is active
  assign rb_ready = !cmd_valid;
  assign wr_en    = cmd_valid || rb_valid;
  assign wr_addr  = cmd_valid ? cmd_addr : rb_addr;
  assign wr_data  = cmd_valid ? cmd_data : rb_wdata;
endmodule

// File: rtl/surf_dbuf.sv
module surf_dbuf
  import surf_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RSV_BITS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vblank,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] stg_stride,
  output logic [DW-1:0] stg_start,
  output logic [DW-1:0] live_stride,
  output logic [DW-1:0] live_start,
  output logic          pending
);
  logic commit, stride_wr, start_wr;

  assign commit    = vblank && pending;
  assign stride_wr = wr_en && (wr_addr == SEL_STRIDE);
  assign start_wr  = wr_en && (wr_addr == SEL_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_stride  <= '0;
      stg_start   <= '0;
      live_stride <= '0;
      live_start  <= '0;
      pending     <= 1'b0;
    end else begin
      if (commit) begin
        live_stride <= stg_stride;
        live_start  <= stg_start;
      end
      if (stride_wr)
        stg_stride <= {wr_data[DW-1:RSV_BITS], {RSV_BITS{1'b0}}};
      if (start_wr)
        stg_start <= wr_data;
      if (start_wr)
        pending <= 1'b1;
      else if (commit)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/surf_stride_chk.sv
module surf_stride_chk #(
  parameter int DW              = 32,
  parameter int TILE_ALIGN_BITS = 8,
  parameter int TILE_MAX        = 16384
) (
  input  logic [DW-1:0] stride,
  input  logic          tiled,
  output logic          bad
);
  localparam logic [DW-1:0] MAX_V = DW'(TILE_MAX);
  logic misaligned, too_big;

  assign misaligned = |stride[TILE_ALIGN_BITS-1:0];
  assign too_big    = stride > MAX_V;
  // linear alignment is guaranteed by the zeroed reserved bits
  assign bad        = tiled && (misaligned || too_big);
endmodule

// File: rtl/sprite_surf_regs.sv
module sprite_surf_regs
  import surf_pkg::*;
#(
  parameter int DW              = 32,
  parameter int RSV_BITS        = 6,
  parameter int TILE_ALIGN_BITS = 8,
  parameter int TILE_MAX        = 16384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tiled,
  input  logic          vblank,
  input  logic          rb_valid,
  output logic          rb_ready,
  input  logic [1:0]    rb_addr,
  input  logic [31:0]   rb_wdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_addr,
  input  logic [31:0]   cmd_data,
  input  logic [1:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic [31:0]   live_stride,
  output logic [31:0]   live_start
);
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] stg_stride, stg_start;
  logic          pending, bad, err, err_clr;

  surf_wr_arb #(.DW(DW)) u_arb (
    .rb_valid(rb_valid), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rb_ready(rb_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  surf_dbuf #(.DW(DW), .RSV_BITS(RSV_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stg_stride(stg_stride), .stg_start(stg_start),
    .live_stride(live_stride), .live_start(live_start), .pending(pending)
  );

  surf_stride_chk #(.DW(DW), .TILE_ALIGN_BITS(TILE_ALIGN_BITS),
                    .TILE_MAX(TILE_MAX)) u_chk_rule (
    .stride(stg_stride), .tiled(tiled), .bad(bad)
  );

  assign err_clr = wr_en && (wr_addr == SEL_STATUS) && wr_data[0];

  // sticky error: a live violation outranks a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (bad)     err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_STRIDE: rd_data = stg_stride;
      SEL_START:  rd_data = stg_start;
      SEL_STATUS: rd_data = {{(DW-2){1'b0}}, pending, err};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sprite_surf_regs_chk.sv
module sprite_surf_regs_chk #(
  parameter int DW       = 32,
  parameter int RSV_BITS = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vblank,
  input logic          cmd_valid,
  input logic          rb_ready,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] stg_stride,
  input logic [DW-1:0] stg_start,
  input logic [DW-1:0] live_stride,
  input logic [DW-1:0] live_start,
  input logic          pending,
  input logic          err
);
  logic start_w, clr_w;
  assign start_w = wr_en && (wr_addr == 2'd1);
  assign clr_w   = wr_en && (wr_addr == 2'd2) && wr_data[0];

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_stride[RSV_BITS-1:0] == '0) && (stg_stride[RSV_BITS-1:0] == '0));

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && pending) |=> (live_stride == $past(stg_stride)) &&
                            (live_start == $past(stg_start)));

  p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && pending && !start_w) |=> !pending);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && pending) |=> $stable(live_stride) && $stable(live_start));

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> pending);

  p_cmd_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rb_ready);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_w) |=> err);
endmodule

bind sprite_surf_regs sprite_surf_regs_chk #(.DW(DW), .RSV_BITS(RSV_BITS)) u_sva (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .cmd_valid(cmd_valid),
  .rb_ready(rb_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .stg_stride(stg_stride), .stg_start(stg_start),
  .live_stride(live_stride), .live_start(live_start),
  .pending(pending), .err(err)
);

// File: tb/sim_sprite_surf_regs.sv
`timescale 1ns/1ps
module sim_sprite_surf_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tiled = 1'b0, vblank = 1'b0;
  logic rb_valid = 1'b0, rb_ready;
  logic [1:0] rb_addr = '0;
  logic [31:0] rb_wdata = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data, live_stride, live_start;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sprite_surf_regs u0 (
    .clk(clk), .rst_n(rst_n), .tiled(tiled), .vblank(vblank),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .live_stride(live_stride), .live_start(live_start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    rb_valid = 1'b1; rb_addr = a; rb_wdata = d;
    @(negedge clk);
    rb_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic vb();
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 stg stride", v, 0);
    rd(2'd1, v); chk("R1 stg start", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 live stride", live_stride, 0);
    chk("R1 live start", live_start, 0);
    chk("R1 rb_ready", {31'b0, rb_ready}, 1);

    // R2 reserved bits
    bus_wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 reserved masked", v, 32'hFFFF_FFC0);
    bus_wr(2'd0, 32'h0000_013F);
    rd(2'd0, v); chk("R2 reserved masked 2", v, 32'h0000_0100);

    // R3 stride alone never commits
    for (int i = 0; i < 5; i++) vb();
    chk("R3 live stride untouched", live_stride, 0);
    rd(2'd2, v); chk("R3 pending low", v & 2, 0);

    // R4 start arms, vblank commits both
    bus_wr(2'd1, 32'h1234_5000);
    rd(2'd2, v); chk("R4 pending set", v & 2, 2);
    chk("R4 live stride before vblank", live_stride, 0);
    vb();
    chk("R4 live stride", live_stride, 32'h0000_0100);
    chk("R4 live start", live_start, 32'h1234_5000);
    rd(2'd2, v); chk("R4 pending cleared", v & 2, 0);

    // R5 vblank without pending
    bus_wr(2'd0, 32'h0000_0800);
    vb(); vb();
    chk("R5 live stride held", live_stride, 32'h0000_0100);
    chk("R5 live start held", live_start, 32'h1234_5000);

    // R6 start write on committing vblank
    bus_wr(2'd1, 32'hAAAA_0000);
    rb_valid = 1'b1; rb_addr = 2'd1; rb_wdata = 32'hBBBB_0000; vblank = 1'b1;
    @(negedge clk);
    rb_valid = 1'b0; vblank = 1'b0;
    chk("R6 commit used old start", live_start, 32'hAAAA_0000);
    chk("R6 commit stride", live_stride, 32'h0000_0800);
    rd(2'd2, v); chk("R6 pending re-armed", v & 2, 2);
    vb();
    chk("R6 next vblank start", live_start, 32'hBBBB_0000);
    rd(2'd2, v); chk("R6 pending cleared", v & 2, 0);

    // R7 command port wins
    rb_valid = 1'b1; rb_addr = 2'd1; rb_wdata = 32'h1111_1000;
    cmd_valid = 1'b1; cmd_addr = 2'd1; cmd_data = 32'h2222_2000;
    #1 chk("R7 rb_ready low", {31'b0, rb_ready}, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    rd(2'd1, v); chk("R7 command applied", v, 32'h2222_2000);
    chk("R7 rb_ready back", {31'b0, rb_ready}, 1);
    @(negedge clk);
    rb_valid = 1'b0;
    rd(2'd1, v); chk("R7 bus applied after", v, 32'h1111_1000);
    vb();

    // R8 tiled sweep, with R9 clear after each
    tiled = 1'b1;
    for (int k = 0; k <= 300; k++) begin
      logic [31:0] s;
      bit e;
      s = k * 64;
      e = ((k % 4) != 0) || (s > 32'd16384);
      bus_wr(2'd0, s);
      @(negedge clk);
      rd(2'd2, v); chk($sformatf("R8 tiled stride %0d", s), v & 1, {31'b0, e});
      bus_wr(2'd0, 32'd0);
      bus_wr(2'd2, 32'd1);
      rd(2'd2, v); chk("R9 clear after fix", v & 1, 0);
    end

    // R8 linear sweep
    tiled = 1'b0;
    for (int k = 0; k <= 300; k += 7) begin
      bus_wr(2'd0, k * 64 + 13);
      @(negedge clk);
      rd(2'd2, v); chk("R8 linear legal", v & 1, 0);
    end

    // R8 mode switch, R9 clear while violation persists
    bus_wr(2'd0, 32'd64);
    @(negedge clk);
    rd(2'd2, v); chk("R8 64 linear ok", v & 1, 0);
    tiled = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R8 64 tiled bad", v & 1, 1);
    bus_wr(2'd2, 32'd1);
    @(negedge clk);
    rd(2'd2, v); chk("R9 stays while bad", v & 1, 1);
    tiled = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R9 sticky after fix", v & 1, 1);
    bus_wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R9 write zero no clear", v & 1, 1);
    bus_wr(2'd2, 32'd1);
    rd(2'd2, v); chk("R9 W1C", v & 1, 0);

    // R10 read map
    bus_wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v); chk("R10 select 3 zero", v, 0);
    rd(2'd0, v); chk("R10 stride select", v, 32'd64);
    rd(2'd1, v); chk("R10 start select", v, 32'h1111_1000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule